// File: doc/BRIEF.md
# Read-Priority Migration Decision Unit

This unit sits beside a non-uniform cache, where latencies differ from place to place. It watches each cache access event and decides whether the block that was touched should move. Two history queues sit outside the unit, one for reads and one for writes. Each queue holds recent block addresses with a use counter and answers a lookup in the same cycle as the access. The unit receives both lookup results on every access. A block whose read counter is above a fixed threshold is moved straight to the single location with the lowest read latency. Failing that, a block whose write counter is above the threshold is moved straight to the location with the lowest write latency. Read intensity takes precedence over write intensity.

The unit has three outputs besides the decision. It sends a one-cycle bump strobe to the queue that matches the access type. On a miss it sends a replace-LRU request. It also presents a migration request carrying a source and a target under a valid/ready handshake. While a migration request is waiting, the unit does not accept new accesses. The queues and the latency-ranking logic are outside this unit; it receives the current fastest-read and fastest-write locations as registered inputs.

Top module: `rpm_decider`

## Requirements
- R1: After reset, `mig_valid`, `rdq_bump`, `wrq_bump` and `lru_req` are 0 and `acc_ready` is 1.
- R2: An accepted hit whose read lookup reports presence with a count strictly above `THRESH` raises `mig_valid` on the next cycle with `mig_src` equal to `acc_loc` and `mig_dst` equal to `best_rd_loc`.
- R3: An accepted hit that is not read-hot, but whose write lookup reports presence with a count strictly above `THRESH`, raises `mig_valid` on the next cycle with `mig_dst` equal to `best_wr_loc`.
- R4: When an accepted hit is both read-hot and write-hot, the target is `best_rd_loc`.
- R5: An accepted hit that is neither read-hot nor write-hot leaves `mig_valid` at 0.
- R6: A count equal to `THRESH` does not make a block hot. A count reported with the lookup's found flag at 0 also does not make a block hot, whatever its value.
- R7: No migration is raised when the chosen target equals `acc_loc`.
- R8: Each accepted access produces exactly one strobe on the next cycle, lasting one cycle, with `evt_addr` equal to `acc_addr`:
  - an accepted write hit pulses `wrq_bump` only;
  - an accepted read hit pulses `rdq_bump` only.
- R9: An accepted miss pulses `lru_req` on the next cycle, with `evt_addr` equal to `acc_addr`. It produces no queue bump and no migration, whatever the lookup inputs.
- R10: While `mig_valid` is 1 and `mig_ready` is 0, `mig_valid`, `mig_src` and `mig_dst` hold their values and `acc_ready` is 0. An access offered in that state produces no strobe. The request clears on the cycle after `mig_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event offered |
| acc_ready | output | 1 | Unit can accept an access (no migration pending) |
| acc_hit | input | 1 | 1 = cache hit, 0 = miss |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_loc | input | LOC_W | Location currently holding the block |
| rdq_hit | input | 1 | Read history queue holds the address |
| rdq_cnt | input | CNT_W | Read history counter for the address |
| wrq_hit | input | 1 | Write history queue holds the address |
| wrq_cnt | input | CNT_W | Write history counter for the address |
| best_rd_loc | input | LOC_W | Location with the lowest read latency |
| best_wr_loc | input | LOC_W | Location with the lowest write latency |
| mig_valid | output | 1 | Migration request pending |
| mig_ready | input | 1 | Migration request taken |
| mig_src | output | LOC_W | Location the block moves from |
| mig_dst | output | LOC_W | Location the block moves to |
| rdq_bump | output | 1 | One-cycle update strobe for the read queue |
| wrq_bump | output | 1 | One-cycle update strobe for the write queue |
| lru_req | output | 1 | One-cycle replace-LRU request on a miss |
| evt_addr | output | ADDR_W | Address attached to the strobes |

## Verification
The bench drives counts that sit exactly on the threshold, and counts that carry a cleared found flag. A design that compared with greater-or-equal, or trusted the count alone, would migrate blocks that are not hot. It builds cases where both queues report hot blocks with different fast locations. A design with write-first priority would send those blocks to the wrong target. It drives misses whose lookup flags claim a hot block, and hits where the block already sits in its target. A faulty design would issue a migration on the miss or a self-move on the hit. It holds `mig_ready` low for several cycles while pushing new accesses. A design that let the request drift, or accepted those accesses, would show changed source or target fields or spurious queue strobes.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_READ  = 2'd1,
    CLS_WRITE = 2'd2
  } cls_e;

  // A block is hot only when present and its count is strictly above the limit.
  function automatic logic is_hot(input logic found, input int unsigned cnt,
                                  input int unsigned limit);
    return found && (cnt > limit);
  endfunction

  // Read intensity outranks write intensity.
  function automatic cls_e pick_class(input logic rd_hot, input logic wr_hot);
    if (rd_hot)      return CLS_READ;
    else if (wr_hot) return CLS_WRITE;
    else             return CLS_NONE;
  endfunction

endpackage

// File: rtl/rpm_classify.sv
module rpm_classify
  import rpm_pkg::*;
#(
  parameter int LOC_W  = 6,
  parameter int CNT_W  = 4,
  parameter int THRESH = 3
) (
  input  logic             hit,
  input  logic [LOC_W-1:0] cur_loc,
  input  logic             rdq_hit,
  input  logic [CNT_W-1:0] rdq_cnt,
  input  logic             wrq_hit,
  input  logic [CNT_W-1:0] wrq_cnt,
  input  logic [LOC_W-1:0] best_rd_loc,
  input  logic [LOC_W-1:0] best_wr_loc,
  output logic             rd_hot,
  output logic             wr_hot,
  output cls_e             cls,
  output logic [LOC_W-1:0] target,
  output logic             want_move
);

  always_comb begin
    rd_hot = is_hot(rdq_hit, int'(unsigned'(rdq_cnt)), THRESH);
    wr_hot = is_hot(wrq_hit, int'(unsigned'(wrq_cnt)), THRESH);
    cls    = pick_class(rd_hot, wr_hot);
    unique case (cls)
      CLS_READ:  target = best_rd_loc;
      CLS_WRITE: target = best_wr_loc;
      default:   target = cur_loc;
    endcase
    want_move = hit && (cls != CLS_NONE) && (target != cur_loc);
  end

endmodule

// File: rtl/rpm_strobes.sv
module rpm_strobes #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              hit,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output logic              rdq_bump,
  output logic              wrq_bump,
  output logic              lru_req,
  output logic [ADDR_W-1:0] evt_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdq_bump <= 1'b0;
      wrq_bump <= 1'b0;
      lru_req  <= 1'b0;
      evt_addr <= '0;
    end else begin
      rdq_bump <= accept && hit && !is_write;
      wrq_bump <= accept && hit && is_write;
      lru_req  <= accept && !hit;
      if (accept) evt_addr <= addr;
    end
  end

endmodule

// File: rtl/rpm_mig_slot.sv
module rpm_mig_slot #(
  parameter int LOC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LOC_W-1:0] src_in,
  input  logic [LOC_W-1:0] dst_in,
  input  logic             mig_ready,
  output logic             mig_valid,
  output logic [LOC_W-1:0] mig_src,
  output logic [LOC_W-1:0] mig_dst
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mig_valid <= 1'b0;
      mig_src   <= '0;
      mig_dst   <= '0;
    end else if (mig_valid) begin
      if (mig_ready) mig_valid <= 1'b0;
    end else if (load) begin
      mig_valid <= 1'b1;
      mig_src   <= src_in;
      mig_dst   <= dst_in;
    end
  end

endmodule

// File: rtl/rpm_decider.sv
module rpm_decider
  import rpm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOC_W  = 6,
  parameter int CNT_W  = 4,
  parameter int THRESH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_hit,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LOC_W-1:0]  acc_loc,
  input  logic              rdq_hit,
  input  logic [CNT_W-1:0]  rdq_cnt,
  input  logic              wrq_hit,
  input  logic [CNT_W-1:0]  wrq_cnt,
  input  logic [LOC_W-1:0]  best_rd_loc,
  input  logic [LOC_W-1:0]  best_wr_loc,
  output logic              mig_valid,
  input  logic              mig_ready,
  output logic [LOC_W-1:0]  mig_src,
  output logic [LOC_W-1:0]  mig_dst,
  output logic              rdq_bump,
  output logic              wrq_bump,
  output logic              lru_req,
  output logic [ADDR_W-1:0] evt_addr
);

  // Named internal events, also watched by the checker.
  logic             accept;
  logic             rd_hot;
  logic             wr_hot;
  cls_e             cls;
  logic [LOC_W-1:0] target;
  logic             want_move;

  assign acc_ready = !mig_valid;
  assign accept    = acc_valid && acc_ready;

  rpm_classify #(.LOC_W(LOC_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_cls (
    .hit        (acc_hit),
    .cur_loc    (acc_loc),
    .rdq_hit    (rdq_hit),
    .rdq_cnt    (rdq_cnt),
    .wrq_hit    (wrq_hit),
    .wrq_cnt    (wrq_cnt),
    .best_rd_loc(best_rd_loc),
    .best_wr_loc(best_wr_loc),
    .rd_hot     (rd_hot),
    .wr_hot     (wr_hot),
    .cls        (cls),
    .target     (target),
    .want_move  (want_move)
  );

  rpm_strobes #(.ADDR_W(ADDR_W)) u_stb (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .hit     (acc_hit),
    .is_write(acc_write),
    .addr    (acc_addr),
    .rdq_bump(rdq_bump),
    .wrq_bump(wrq_bump),
    .lru_req (lru_req),
    .evt_addr(evt_addr)
  );

  rpm_mig_slot #(.LOC_W(LOC_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && want_move),
    .src_in   (acc_loc),
    .dst_in   (target),
    .mig_ready(mig_ready),
    .mig_valid(mig_valid),
    .mig_src  (mig_src),
    .mig_dst  (mig_dst)
  );

endmodule

// File: rtl/rpm_checker.sv
module rpm_checker #(
  parameter int LOC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             acc_ready,
  input logic             acc_hit,
  input logic             acc_write,
  input logic [LOC_W-1:0] acc_loc,
  input logic [LOC_W-1:0] best_rd_loc,
  input logic [LOC_W-1:0] best_wr_loc,
  input logic             rd_hot,
  input logic             wr_hot,
  input logic             mig_valid,
  input logic             mig_ready,
  input logic [LOC_W-1:0] mig_src,
  input logic [LOC_W-1:0] mig_dst,
  input logic             rdq_bump,
  input logic             wrq_bump,
  input logic             lru_req
);

  assert_rd_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_hit && rd_hot && (acc_loc != best_rd_loc)
    |=> mig_valid && (mig_dst == $past(best_rd_loc)) && (mig_src == $past(acc_loc)));

  assert_wr_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_hit && !rd_hot && wr_hot && (acc_loc != best_wr_loc)
    |=> mig_valid && (mig_dst == $past(best_wr_loc)));

  assert_cold_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !rd_hot && !wr_hot |=> !mig_valid);

  assert_no_self_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mig_valid) |-> (mig_src != mig_dst));

  assert_write_bump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_hit && acc_write |=> wrq_bump && !rdq_bump && !lru_req);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rdq_bump, wrq_bump, lru_req}) <= 1);

  assert_miss_only_lru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !acc_hit |=> lru_req && !mig_valid && !rdq_bump && !wrq_bump);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid && !mig_ready |=> mig_valid && $stable(mig_src) && $stable(mig_dst));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> !acc_ready);

endmodule

bind rpm_decider rpm_checker #(.LOC_W(LOC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .acc_ready  (acc_ready),
  .acc_hit    (acc_hit),
  .acc_write  (acc_write),
  .acc_loc    (acc_loc),
  .best_rd_loc(best_rd_loc),
  .best_wr_loc(best_wr_loc),
  .rd_hot     (rd_hot),
  .wr_hot     (wr_hot),
  .mig_valid  (mig_valid),
  .mig_ready  (mig_ready),
  .mig_src    (mig_src),
  .mig_dst    (mig_dst),
  .rdq_bump   (rdq_bump),
  .wrq_bump   (wrq_bump),
  .lru_req    (lru_req)
);

// File: tb/sim_rpm_decider.sv
module sim_rpm_decider;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LOC_W  = 6;
  localparam int CNT_W  = 4;
  localparam int THRESH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0, acc_hit = 1'b0, acc_write = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [LOC_W-1:0]  acc_loc = '0, best_rd_loc = '0, best_wr_loc = '0;
  logic              rdq_hit = 1'b0, wrq_hit = 1'b0, mig_ready = 1'b0;
  logic [CNT_W-1:0]  rdq_cnt = '0, wrq_cnt = '0;
  logic              acc_ready, mig_valid, rdq_bump, wrq_bump, lru_req;
  logic [LOC_W-1:0]  mig_src, mig_dst;
  logic [ADDR_W-1:0] evt_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpm_decider #(.ADDR_W(ADDR_W), .LOC_W(LOC_W), .CNT_W(CNT_W), .THRESH(THRESH)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_hit(acc_hit), .acc_write(acc_write), .acc_addr(acc_addr), .acc_loc(acc_loc),
    .rdq_hit(rdq_hit), .rdq_cnt(rdq_cnt), .wrq_hit(wrq_hit), .wrq_cnt(wrq_cnt),
    .best_rd_loc(best_rd_loc), .best_wr_loc(best_wr_loc), .mig_valid(mig_valid),
    .mig_ready(mig_ready), .mig_src(mig_src), .mig_dst(mig_dst), .rdq_bump(rdq_bump),
    .wrq_bump(wrq_bump), .lru_req(lru_req), .evt_addr(evt_addr)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Bench model of the hot test: present and strictly above the limit.
  function automatic bit hot(input bit f, input int c);
    return f && (c > THRESH);
  endfunction

  task automatic access(input bit hit, input bit wr, input logic [ADDR_W-1:0] a,
                        input int loc, input bit rf, input int rc, input bit wf,
                        input int wc, input int br, input int bw, input int hold);
    bit rh, wh, mv;
    int tgt;
    string tag;
    logic [LOC_W-1:0] s0, d0;
    rh  = hot(rf, rc);
    wh  = hot(wf, wc);
    tgt = rh ? br : (wh ? bw : loc);
    mv  = hit && (rh || wh) && (tgt != loc);
    if (!hit)                                          tag = "R9";
    else if ((rf && rc == THRESH) || (wf && wc == THRESH) ||
             (!rf && rc > THRESH) || (!wf && wc > THRESH)) tag = "R6";
    else if ((rh || wh) && tgt == loc)                 tag = "R7";
    else if (rh && wh)                                 tag = "R4";
    else if (rh)                                       tag = "R2";
    else if (wh)                                       tag = "R3";
    else                                               tag = "R5";
    @(negedge clk);
    acc_valid = 1; acc_hit = hit; acc_write = wr; acc_addr = a;
    acc_loc = LOC_W'(loc); rdq_hit = rf; rdq_cnt = CNT_W'(rc);
    wrq_hit = wf; wrq_cnt = CNT_W'(wc);
    best_rd_loc = LOC_W'(br); best_wr_loc = LOC_W'(bw);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    chk("R8", "rdq_bump", rdq_bump, hit && !wr);
    chk("R8", "wrq_bump", wrq_bump, hit && wr);
    chk("R9", "lru_req", lru_req, !hit);
    chk("R8", "evt_addr", evt_addr, a);
    chk(tag, "mig_valid", mig_valid, mv);
    if (mv) begin
      chk(tag, "mig_dst", mig_dst, tgt);
      chk(tag, "mig_src", mig_src, loc);
      s0 = mig_src; d0 = mig_dst;
      for (int i = 0; i < hold; i++) begin
        // Offer an access while stalled; it must leave no trace.
        acc_valid = (i == 0); acc_hit = 1; acc_write = i[0];
        acc_addr = a ^ 32'hFFFF; rdq_hit = 1; rdq_cnt = '1;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 0;
        chk("R10", "held mig_valid", mig_valid, 1);
        chk("R10", "held mig_src", mig_src, s0);
        chk("R10", "held mig_dst", mig_dst, d0);
        chk("R10", "acc_ready", acc_ready, 0);
        chk("R10", "stall strobes", {rdq_bump, wrq_bump, lru_req}, 0);
      end
      mig_ready = 1;
      @(posedge clk);
      @(negedge clk);
      mig_ready = 0;
      chk("R10", "cleared mig_valid", mig_valid, 0);
      chk("R10", "acc_ready back", acc_ready, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "mig_valid", mig_valid, 0);
    chk("R1", "acc_ready", acc_ready, 1);
    chk("R1", "strobes", {rdq_bump, wrq_bump, lru_req}, 0);

    // Directed corners
    access(1, 0, 32'h100, 5, 1, 9, 0, 0, 2, 7, 2);   // read hot -> best read
    access(1, 1, 32'h104, 5, 0, 0, 1, 8, 2, 7, 0);   // write hot -> best write
    access(1, 1, 32'h108, 5, 1, 4, 1, 15, 2, 7, 1);  // both hot -> read wins
    access(1, 0, 32'h10C, 5, 1, 3, 1, 3, 2, 7, 0);   // equal to limit -> cold
    access(1, 0, 32'h110, 5, 0, 15, 0, 15, 2, 7, 0); // counts without found flag
    access(1, 0, 32'h114, 2, 1, 9, 0, 0, 2, 7, 0);   // already at read target
    access(1, 1, 32'h118, 7, 0, 0, 1, 9, 2, 7, 0);   // already at write target
    access(0, 1, 32'h11C, 5, 1, 9, 1, 9, 2, 7, 0);   // miss with hot flags
    access(0, 0, 32'h120, 5, 0, 0, 0, 0, 2, 7, 0);   // read miss
    access(1, 0, 32'h124, 5, 0, 0, 0, 0, 2, 7, 0);   // cold hit

    // Constrained random, fixed seed, small ranges so corners recur
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      access($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom(),
             $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 15),
             $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule